// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller made of a parameterised number of banks. Each bank serves up to 32 pins and has a usable width, set per bank at build time. Lanes at or above that width are inert. Software reaches each bank's eight 32-bit registers over a word-addressed register port. The port writes in one cycle and reads combinationally. On the pad side every pin has an input, an output value and an output enable. Each pin can be a push-pull output, an open-drain output or an input.

Every pin input passes through a two-flop synchroniser. A per-pin detector then watches the synchronised value for a level or an edge. Three per-pin configuration bits choose the detection mode:

| Level bit | Both-edge bit | Polarity bit | Mode |
|---|---|---|---|
| 1 | any | 0 | active-low level |
| 1 | any | 1 | active-high level |
| 0 | 1 | ignored | both edges |
| 0 | 0 | 0 | falling edge |
| 0 | 0 | 1 | rising edge |

A detected event latches a sticky flag. Software clears a flag by writing 1 to it. The flags of all banks, each gated by its enable bit, are ORed into one interrupt output. There is no state machine. Each bank is a set of registers, and each pin has a small compare stage behind its synchroniser.

Top module: `pinbank_ctrl`

## Requirements
- R1: Bank b occupies word addresses 8b to 8b+7, that is byte offset 32b. Its word offsets 0 to 7 are, in order: open-drain enable, output value, direction, polarity, both-edge, interrupt enable, level select and flag. Word addresses of banks that do not exist read as 0.
- R2: A direction bit of 0 makes the pin an output. With the open-drain bit 0, the pin drives pad_oe=1 and pad_out equal to the output-value bit. A direction bit of 1 makes the pin an input with pad_oe=0.
- R3: An output pin whose open-drain bit is 1 never drives high. An output-value bit of 0 gives pad_oe=1 and pad_out=0. An output-value bit of 1 gives pad_oe=0.
- R4: Reading the output-value register returns the synchronised pad level for input pins and the stored value for output pins.
- R5: With the level bit at 1, the flag is set on every cycle in which the synchronised input equals the polarity bit (0 means low-active, 1 means high-active). A clear therefore has no lasting effect while that level persists.
- R6: With the level and both-edge bits at 0, a polarity bit of 1 sets the flag on a rising edge only. A polarity bit of 0 sets it on a falling edge only.
- R7: With the level bit at 0 and the both-edge bit at 1, both edges set the flag, whatever the polarity bit holds.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A flag is only set by a detected event. When an event and a clear of the same bit fall in the same cycle, the bit is set.
- R9: irq is 1 exactly when some bank has a flag bit whose interrupt-enable bit is also 1. Pending bits from different banks are ORed together.
- R10: Lanes at or above a bank's width read as 0 in every register, never drive a pad and never raise a flag.
- R11: After reset, direction is all input (all usable lanes set to 1). Open-drain, output value, polarity, both-edge, enable, level and flag are all 0, and irq is 0.
- R12: A pad change reaches the flag no sooner than the third rising clock edge after it: two synchroniser edges, then the edge that latches the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W | Word address: bank index in the upper bits, register index in bits [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32*NUM_BANKS | Pad input levels, bank b in bits [32b+31:32b] |
| pad_out | output | 32*NUM_BANKS | Pad output values |
| pad_oe | output | 32*NUM_BANKS | Pad output enables |
| irq | output | 1 | OR of enabled flags over all banks |

## Verification
The bound checker holds the following on every cycle:

- Input pins and inert lanes never drive a pad.
- Open-drain outputs never drive high.
- No flag rises without a detected event on the cycle before.
- A detected event always leaves its flag set, even when a clear arrives in the same cycle.
- irq stays low while every enable bit is 0.

The bench's directed scenarios cover what a property cannot express without copying the detector:

- that each of the five detection modes reacts to the right edge or level and to nothing else;
- the exact three-edge latency from pad to flag;
- the readback mix of pad and stored values;
- the address map;
- the way a held level defeats a clear.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int LANE_MAX = 32;
    localparam int REGS_PER_BANK = 8;

    // Word offset of each register inside a bank; the order is the address map.
    typedef enum logic [2:0] {
        RG_OPEN   = 3'd0,  // open-drain enable
        RG_VALUE  = 3'd1,  // output value / pin readback
        RG_DIR    = 3'd2,  // 1 = input, 0 = output
        RG_POL    = 3'd3,  // polarity / edge select
        RG_ANY    = 3'd4,  // both-edge select
        RG_ENABLE = 3'd5,  // interrupt enable
        RG_LEVEL  = 3'd6,  // level select
        RG_FLAG   = 3'd7   // sticky flag, write 1 to clear
    } reg_idx_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            synced <= '0;
        end else begin
            meta_q <= raw;
            synced <= meta_q;
        end
    end

endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_now,
    input  logic [W-1:0] sel_level,
    input  logic [W-1:0] sel_pol,
    input  logic [W-1:0] sel_any,
    output logic [W-1:0] event_hit
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_now;
    end

    assign rise = lvl_now & ~prev_q;
    assign fall = ~lvl_now & prev_q;

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb begin
            if (sel_level[i])
                event_hit[i] = ~(lvl_now[i] ^ sel_pol[i]);
            else if (sel_any[i])
                event_hit[i] = rise[i] | fall[i];
            else
                event_hit[i] = sel_pol[i] ? rise[i] : fall[i];
        end
    end

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_idx_e    reg_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [31:0] pin_sync,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic [31:0] flag_q,
    output logic [31:0] enable_q,
    output logic [31:0] dir_q,
    output logic [31:0] open_q,
    output logic [31:0] hit,
    output logic        pend
);

    localparam logic [31:0] LMASK = 32'((33'd1 << LANES) - 33'd1);

    logic [31:0] value_q, pol_q, any_q, level_q;
    logic [31:0] wmask, clr, raw_hit;

    assign wmask = wr_data & LMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q   <= '0;
            value_q  <= '0;
            dir_q    <= LMASK;
            pol_q    <= '0;
            any_q    <= '0;
            enable_q <= '0;
            level_q  <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                RG_OPEN:   open_q   <= wmask;
                RG_VALUE:  value_q  <= wmask;
                RG_DIR:    dir_q    <= wmask;
                RG_POL:    pol_q    <= wmask;
                RG_ANY:    any_q    <= wmask;
                RG_ENABLE: enable_q <= wmask;
                RG_LEVEL:  level_q  <= wmask;
                RG_FLAG:   ;
            endcase
        end
    end

    pinbank_detect #(.W(32)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_now   (pin_sync),
        .sel_level (level_q),
        .sel_pol   (pol_q),
        .sel_any   (any_q),
        .event_hit (raw_hit)
    );

    assign hit = raw_hit & LMASK;
    assign clr = (wr_en && reg_sel == RG_FLAG) ? wr_data : '0;

    // Set beats clear: the hit term is ORed after the clear is applied.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ((flag_q & ~clr) | hit) & LMASK;
    end

    assign pend = |(flag_q & enable_q);

    // Pad drive: open-drain outputs only pull low.
    assign pin_oe  = ~dir_q & LMASK & ~(open_q & value_q);
    assign pin_out = ~dir_q & LMASK & ~open_q & value_q;

    always_comb begin
        unique case (reg_sel)
            RG_OPEN:   rd_data = open_q;
            RG_VALUE:  rd_data = ((dir_q & pin_sync) | (~dir_q & value_q)) & LMASK;
            RG_DIR:    rd_data = dir_q;
            RG_POL:    rd_data = pol_q;
            RG_ANY:    rd_data = any_q;
            RG_ENABLE: rd_data = enable_q;
            RG_LEVEL:  rd_data = level_q;
            RG_FLAG:   rd_data = flag_q;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int                        NUM_BANKS  = 2,
    parameter logic [NUM_BANKS*6-1:0]    BANK_LANES = {6'd20, 6'd32},
    parameter int                        BANK_BITS  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int                        ADDR_W     = BANK_BITS + 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*32-1:0]   pad_in,
    output logic [NUM_BANKS*32-1:0]   pad_out,
    output logic [NUM_BANKS*32-1:0]   pad_oe,
    output logic                      irq
);

    localparam int PW = NUM_BANKS * LANE_MAX;

    logic [PW-1:0]        pin_sync;
    logic [PW-1:0]        flag_all, enable_all, dir_all, open_all, hit_all, lane_all;
    logic [NUM_BANKS-1:0] pend;
    logic [31:0]          rd_bank [NUM_BANKS];
    logic [BANK_BITS-1:0] bank_idx;
    reg_idx_e             reg_sel;

    assign bank_idx = bus_addr[ADDR_W-1:3];
    assign reg_sel  = reg_idx_e'(bus_addr[2:0]);

    pinbank_sync #(.W(PW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LN = int'(BANK_LANES[b*6 +: 6]);
        logic sel;
        assign sel = bus_we && (bank_idx == BANK_BITS'(b));
        assign lane_all[b*32 +: 32] = 32'((33'd1 << LN) - 33'd1);

        pinbank_bank #(.LANES(LN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .reg_sel  (reg_sel),
            .wr_data  (bus_wdata),
            .rd_data  (rd_bank[b]),
            .pin_sync (pin_sync[b*32 +: 32]),
            .pin_out  (pad_out[b*32 +: 32]),
            .pin_oe   (pad_oe[b*32 +: 32]),
            .flag_q   (flag_all[b*32 +: 32]),
            .enable_q (enable_all[b*32 +: 32]),
            .dir_q    (dir_all[b*32 +: 32]),
            .open_q   (open_all[b*32 +: 32]),
            .hit      (hit_all[b*32 +: 32]),
            .pend     (pend[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_idx == BANK_BITS'(b)) bus_rdata = rd_bank[b];
    end

    assign irq = |pend;

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] flag_all,
    input logic [W-1:0] enable_all,
    input logic [W-1:0] dir_all,
    input logic [W-1:0] open_all,
    input logic [W-1:0] hit_all,
    input logic [W-1:0] lane_all
);

    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_all) == '0); // R2

    AST_ODRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & open_all) == '0); // R3

    AST_INERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_all | pad_oe) & ~lane_all) == '0); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_all != '0) |=> ((flag_all & $past(hit_all)) == $past(hit_all))); // R8

    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_all & ~$past(flag_all) & ~$past(hit_all)) == '0)); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_all == '0) |-> !irq); // R9

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.W(NUM_BANKS*32)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .flag_all   (flag_all),
    .enable_all (enable_all),
    .dir_all    (dir_all),
    .open_all   (open_all),
    .hit_all    (hit_all),
    .lane_all   (lane_all)
);

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;

    localparam int NB = 2;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB*32-1:0] pad_in = '0;
    logic [NB*32-1:0] pad_out, pad_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pinbank_ctrl #(.NUM_BANKS(NB), .BANK_LANES({6'd20, 6'd32})) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // word offsets
    localparam int O_OPEN = 0, O_VAL = 1, O_DIR = 2, O_POL = 3,
                   O_ANY = 4, O_EN = 5, O_LVL = 6, O_FLAG = 7;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        pad_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input int bank, input int off, input logic [31:0] d);
        bus_addr = AW'(bank * 8 + off);
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int bank, input int off, output logic [31:0] d);
        bus_addr = AW'(bank * 8 + off);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(0, O_DIR, d);  chk("R11 bank0 dir reset", 64'(d), 64'hFFFF_FFFF);
        rd(1, O_DIR, d);  chk("R11 bank1 dir reset (R10 width 20)", 64'(d), 64'h000F_FFFF);
        rd(0, O_EN, d);   chk("R11 enable reset", 64'(d), 64'h0);
        rd(1, O_FLAG, d); chk("R11 flag reset", 64'(d), 64'h0);
        chk("R11 pad_oe reset", pad_oe, 64'h0);
        chk("R11 irq reset", 64'(irq), 64'h0);
    endtask

    task automatic t_addr_map();
        logic [31:0] d;
        do_reset();
        wr(1, O_EN, 32'h5);
        rd(1, O_EN, d); chk("R1 bank1 enable at word 13", 64'(d), 64'h5);
        rd(0, O_EN, d); chk("R1 bank0 enable untouched", 64'(d), 64'h0);
        wr(0, O_POL, 32'hA5);
        rd(0, O_POL, d); chk("R1 bank0 polarity at word 3", 64'(d), 64'hA5);
        rd(1, O_POL, d); chk("R1 bank1 polarity untouched", 64'(d), 64'h0);
    endtask

    task automatic t_drive();
        logic [31:0] d;
        do_reset();
        wr(0, O_DIR, 32'hFFFF_FFF0);
        wr(0, O_VAL, 32'h5);
        chk("R2 push-pull oe", 64'(pad_oe[3:0]), 64'hF);
        chk("R2 push-pull out", 64'(pad_out[3:0]), 64'h5);
        wr(0, O_OPEN, 32'h3);
        chk("R3 open-drain oe", 64'(pad_oe[3:0]), 64'hE);
        chk("R3 open-drain out", 64'(pad_out[3:0]), 64'h4);
        pad_in[8] = 1'b1;
        wait_cyc(3);
        rd(0, O_VAL, d); chk("R4 readback mix", 64'(d), 64'h105);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        do_reset();
        wr(0, O_POL, 32'h400);
        wr(0, O_EN, 32'h400);
        pad_in[10] = 1'b1;
        wait_cyc(2);
        rd(0, O_FLAG, d); chk("R12 no flag after two edges", 64'(d[10]), 64'h0);
        wait_cyc(1);
        rd(0, O_FLAG, d); chk("R12/R6 rising flag on third edge", 64'(d[10]), 64'h1);
        chk("R9 irq from bank0", 64'(irq), 64'h1);
        wr(0, O_FLAG, 32'h400);
        rd(0, O_FLAG, d); chk("R8 write-1 clears", 64'(d[10]), 64'h0);
        chk("R9 irq drops", 64'(irq), 64'h0);
        pad_in[10] = 1'b0;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R6 rising ignores fall", 64'(d[10]), 64'h0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        do_reset();
        pad_in[11] = 1'b1;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R6 falling ignores rise", 64'(d[11]), 64'h0);
        pad_in[11] = 1'b0;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R6 falling flag", 64'(d[11]), 64'h1);
    endtask

    task automatic t_both();
        logic [31:0] d;
        do_reset();
        wr(0, O_ANY, 32'h1000);
        wr(0, O_POL, 32'h1000);
        pad_in[12] = 1'b1;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R7 both-edge rise", 64'(d[12]), 64'h1);
        wr(0, O_FLAG, 32'h1000);
        rd(0, O_FLAG, d); chk("R7 cleared", 64'(d[12]), 64'h0);
        pad_in[12] = 1'b0;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R7 both-edge fall, polarity ignored", 64'(d[12]), 64'h1);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        do_reset();
        wr(0, O_LVL, 32'h2000);
        wr(0, O_POL, 32'h2000);
        pad_in[13] = 1'b1;
        wait_cyc(4);
        rd(0, O_FLAG, d); chk("R5 level-high flag", 64'(d[13]), 64'h1);
        wr(0, O_FLAG, 32'h2000);
        rd(0, O_FLAG, d); chk("R5/R8 clear loses while level held", 64'(d[13]), 64'h1);
        pad_in[13] = 1'b0;
        wait_cyc(4);
        wr(0, O_FLAG, 32'h2000);
        rd(0, O_FLAG, d); chk("R5 clear sticks once level gone", 64'(d[13]), 64'h0);
    endtask

    task automatic t_level_low_mask();
        logic [31:0] d;
        do_reset();
        wr(1, O_LVL, 32'h4);
        wait_cyc(2);
        rd(1, O_FLAG, d); chk("R5 level-low flag bank1", 64'(d), 64'h4);
        chk("R9 masked flag keeps irq low", 64'(irq), 64'h0);
        wr(1, O_FLAG, 32'h0);
        rd(1, O_FLAG, d); chk("R8 write-0 leaves flag", 64'(d), 64'h4);
        wr(1, O_EN, 32'h4);
        chk("R9 irq from bank1 alone", 64'(irq), 64'h1);
    endtask

    task automatic t_inert();
        logic [31:0] d;
        do_reset();
        wr(1, O_DIR, 32'h0);
        wr(1, O_VAL, 32'hFFFF_FFFF);
        rd(1, O_DIR, d); chk("R10 dir reads zero-width lanes", 64'(d), 64'h0);
        rd(1, O_VAL, d); chk("R10 value readback clipped", 64'(d), 64'h000F_FFFF);
        chk("R10 inert lanes not driven", 64'(pad_oe[63:32]), 64'h000F_FFFF);
        wr(1, O_ANY, 32'hFFFF_FFFF);
        wr(1, O_EN, 32'hFFFF_FFFF);
        pad_in[63:52] = 12'hFFF;
        wait_cyc(4);
        pad_in[63:52] = 12'h000;
        wait_cyc(4);
        rd(1, O_FLAG, d); chk("R10 inert lanes raise no flag", 64'(d), 64'h0);
        chk("R10 irq quiet", 64'(irq), 64'h0);
        rd(1, O_EN, d); chk("R10 enable clipped", 64'(d), 64'h000F_FFFF);
    endtask

    task automatic t_no_bank();
        logic [31:0] d;
        do_reset();
        bus_addr = AW'(4'hF);
        #1;
        d = bus_rdata;
        chk("R1 upper map reads bank1 flag", 64'(d), 64'h0);
    endtask

    initial begin
        t_reset();
        t_addr_map();
        t_drive();
        t_rise();
        t_fall();
        t_both();
        t_level_high();
        t_level_low_mask();
        t_inert();
        t_no_bank();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule